// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port RAM

This block is a two-port synchronous memory with one write port and one read port, each on its own clock. It holds 2048 words of 32 bits. Every word is stored together with seven check bits of an extended Hamming code: six Hamming bits plus one bit of overall even parity. The check bits either come from the built-in encoder or, with the encoder turned off, from a write-side input. Turning the encoder off is also how a system writes a deliberately inconsistent word.

On a read, the decoder repairs any single flipped bit in the word it presents and raises a single-error flag in the same cycle. A word with two flipped bits is presented as stored, and a double-error flag follows one read-clock cycle later. The memory itself is never rewritten by the read side. The block also reports the address of the word it is currently presenting. An optional output stage adds one cycle of latency. It has its own clock enable, and its reset can be set either to override the enable or to act only while the enable is high.

Top module: `ecc_sdp_ram`

## Requirements
- R1: A read issued with rd_en high at a rd_clk edge presents the word stored at rd_addr on rd_data right after that edge when OUT_REG=0. A clean word comes back unchanged with rd_sbe and rd_dbe low.
- R2: enc_chk shows the seven check bits of wr_data. Codeword positions run from 1 to 38, and the power-of-two positions are reserved for check bits. Data bit i sits at the i-th remaining position, counted upward. Bit j (0..5) is the XOR of the data bits whose position has bit j set. Bit 6 is the XOR of all 32 data bits and those six bits.
- R3: With ENC_EN=1 the stored check bits are the encoder's. With ENC_EN=0 they are taken from wr_chk.
- R4: When exactly one of the 39 stored bits is wrong, rd_data carries the corrected data word and rd_sbe is high in the same cycle as that word.
- R5: A corrected word is not repaired in memory: reading the same address again raises rd_sbe again.
- R6: When exactly two stored bits are wrong, rd_data carries the stored data bits unchanged and rd_sbe stays low. rd_dbe is high one rd_clk cycle after that word appears.
- R7: rd_addr_out is the address of the word currently on rd_data.
- R8: With OUT_REG=0 and rd_en low, rd_data, rd_sbe and rd_addr_out hold their values, and writes do not disturb them.
- R9: With OUT_REG=1, results appear one rd_clk cycle later than in R1. The output stage loads only when oreg_ce is high and holds otherwise.
- R10: With OUT_REG=1 and PRIO=PRIO_RST, rd_rst loads RST_VAL into rd_data whatever oreg_ce is. With PRIO=PRIO_CE, rd_rst acts only while oreg_ce is high.
- R11: With DEC_EN=0, rd_data is the stored data bits and both error flags stay low.
- R12: After rd_rst with OUT_REG=0, rd_data, rd_addr_out, rd_sbe and rd_dbe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 11 | Write address |
| wr_data | input | 32 | Write data |
| wr_chk | input | 7 | Check bits stored when the encoder is off |
| enc_chk | output | 7 | Encoder check bits for wr_data |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high read-side reset |
| rd_en | input | 1 | Read enable, active high |
| rd_addr | input | 11 | Read address |
| oreg_ce | input | 1 | Output stage clock enable |
| rd_data | output | 32 | Read data, corrected when possible |
| rd_sbe | output | 1 | Single-bit error corrected, aligned with rd_data |
| rd_dbe | output | 1 | Double-bit error, one cycle after its word |
| rd_addr_out | output | 11 | Address of the word on rd_data |

## Verification
If the syndrome-to-bit mapping is wrong, a single injected fault shows up on rd_data in the very cycle the word is presented: the bad bit remains and a good bit is flipped, while rd_sbe may still look right. So the data is compared as well as the flag. If the double-error flag is mistimed, it appears on the wrong read, because reads are spaced so that each double-error flag is compared exactly one cycle after its word. If the output stage, its enable or its reset priority is wrong, stale or reset data appears on rd_data one cycle after the deciding edge. The held-read case and the re-read of a corrected address expose any hidden write-back or any unintended reload.

// File: rtl/ecc_sdp_pkg.sv
package ecc_sdp_pkg;

  localparam int unsigned MAXW = 256;

  typedef enum logic {PRIO_RST = 1'b0, PRIO_CE = 1'b1} oreg_prio_e;

  // Hamming bits plus one overall parity bit
  function automatic int unsigned chk_width(int unsigned dw);
    int unsigned r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r + 1;
  endfunction

  // codeword position of data bit i (powers of two are skipped)
  function automatic int unsigned data_pos(int unsigned i);
    int unsigned n;
    n = 0;
    for (int unsigned p = 1; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) return p;
        n++;
      end
    end
    return 0;
  endfunction

  // data bits covered by Hamming check bit j
  function automatic logic [MAXW-1:0] cover_mask(int unsigned j, int unsigned dw);
    logic [MAXW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < dw; i++)
      if (((data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc import ecc_sdp_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]              data_i,
  output logic [chk_width(DW)-1:0]   chk_o
);
  localparam int unsigned CW = chk_width(DW);
  localparam int unsigned R  = CW - 1;

  logic [R-1:0] h;

  for (genvar j = 0; j < R; j++) begin : g_h
    localparam logic [MAXW-1:0] M = cover_mask(j, DW);
    assign h[j] = ^(data_i & M[DW-1:0]);
  end

  assign chk_o = {^{data_i, h}, h};
endmodule

// File: rtl/secded_dec.sv
module secded_dec import ecc_sdp_pkg::*; #(
  parameter int unsigned DW = 32,
  parameter bit          EN = 1'b1
) (
  input  logic [DW-1:0]            data_i,
  input  logic [chk_width(DW)-1:0] chk_i,
  output logic [DW-1:0]            data_o,
  output logic                     single_o,
  output logic                     double_o
);
  localparam int unsigned CW = chk_width(DW);
  localparam int unsigned R  = CW - 1;

  if (EN) begin : g_on
    logic [CW-1:0] re;
    logic [R-1:0]  syn;
    logic          odd;
    logic [DW-1:0] flip;

    secded_enc #(.DW(DW)) u_re (.data_i(data_i), .chk_o(re));

    assign syn = chk_i[R-1:0] ^ re[R-1:0];
    // parity over every stored bit: re[R] ^ ^re[R-1:0] equals ^data_i
    assign odd = re[R] ^ (^re[R-1:0]) ^ (^chk_i);

    for (genvar i = 0; i < DW; i++) begin : g_fix
      localparam int unsigned P = data_pos(i);
      assign flip[i] = odd && (syn == R'(P));
    end

    assign data_o   = data_i ^ flip;
    assign single_o = odd;
    assign double_o = !odd && (syn != '0);
  end else begin : g_off
    logic [CW-1:0] unused_chk;
    assign unused_chk = chk_i;
    assign data_o   = data_i;
    assign single_o = 1'b0;
    assign double_o = 1'b0;
  end
endmodule

// File: rtl/sdp_mem.sv
module sdp_mem #(
  parameter int unsigned W  = 39,
  parameter int unsigned AW = 11
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram import ecc_sdp_pkg::*; #(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 11,
  parameter bit          OUT_REG = 1'b0,
  parameter bit          ENC_EN  = 1'b1,
  parameter bit          DEC_EN  = 1'b1,
  parameter oreg_prio_e  PRIO    = PRIO_RST,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic                     wr_clk,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [chk_width(DW)-1:0] wr_chk,
  output logic [chk_width(DW)-1:0] enc_chk,
  input  logic                     rd_clk,
  input  logic                     rd_rst,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  input  logic                     oreg_ce,
  output logic [DW-1:0]            rd_data,
  output logic                     rd_sbe,
  output logic                     rd_dbe,
  output logic [AW-1:0]            rd_addr_out
);
  localparam int unsigned CW = chk_width(DW);
  localparam int unsigned WW = DW + CW;

  logic [CW-1:0] enc_bits, store_chk;
  logic [WW-1:0] word_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] dec_data;
  logic          dec_sbe, dec_dbl, dbe_src, dbe_q;

  // write side
  secded_enc #(.DW(DW)) u_enc (.data_i(wr_data), .chk_o(enc_bits));

  always_comb store_chk = ENC_EN ? enc_bits : wr_chk;
  assign enc_chk = enc_bits;

  sdp_mem #(.W(WW), .AW(AW)) u_mem (
    .wr_clk (wr_clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_word({store_chk, wr_data}),
    .rd_clk (rd_clk),
    .rd_rst (rd_rst),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_word(word_q)
  );

  // read side, first stage: address of the fetched word
  always_ff @(posedge rd_clk) begin
    if (rd_rst)     addr_q <= '0;
    else if (rd_en) addr_q <= rd_addr;
  end

  secded_dec #(.DW(DW), .EN(DEC_EN)) u_dec (
    .data_i  (word_q[DW-1:0]),
    .chk_i   (word_q[WW-1:DW]),
    .data_o  (dec_data),
    .single_o(dec_sbe),
    .double_o(dec_dbl)
  );

  if (OUT_REG) begin : g_oreg
    logic [DW-1:0] o_data;
    logic [AW-1:0] o_addr;
    logic          o_sbe, o_dbl;

    always_ff @(posedge rd_clk) begin
      if (rd_rst && (PRIO == PRIO_RST || oreg_ce)) begin
        o_data <= RST_VAL;
        o_addr <= '0;
        o_sbe  <= 1'b0;
        o_dbl  <= 1'b0;
      end else if (oreg_ce) begin
        o_data <= dec_data;
        o_addr <= addr_q;
        o_sbe  <= dec_sbe;
        o_dbl  <= dec_dbl;
      end
    end

    assign rd_data     = o_data;
    assign rd_addr_out = o_addr;
    assign rd_sbe      = o_sbe;
    assign dbe_src     = o_dbl;
  end else begin : g_direct
    logic unused_ce;
    assign unused_ce   = oreg_ce;
    assign rd_data     = dec_data;
    assign rd_addr_out = addr_q;
    assign rd_sbe      = dec_sbe;
    assign dbe_src     = dec_dbl;
  end

  // double-error flag trails its word by one read cycle
  always_ff @(posedge rd_clk) begin
    if (rd_rst) dbe_q <= 1'b0;
    else        dbe_q <= dbe_src;
  end

  assign rd_dbe = dbe_q;
endmodule

// File: rtl/ecc_sdp_ram_chk.sv
module ecc_sdp_ram_chk import ecc_sdp_pkg::*; #(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 11,
  parameter bit          OUT_REG = 1'b0,
  parameter bit          DEC_EN  = 1'b1,
  parameter oreg_prio_e  PRIO    = PRIO_RST,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input logic          rd_clk,
  input logic          rd_rst,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          oreg_ce,
  input logic [DW-1:0] rd_data,
  input logic          rd_sbe,
  input logic          rd_dbe,
  input logic [AW-1:0] rd_addr_out
);
  logic prev_rst, prev_ce;
  always @(posedge rd_clk) begin
    prev_rst <= rd_rst;
    prev_ce  <= oreg_ce;
  end

  // R6
  flag_excl_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_dbe |-> !$past(rd_sbe));

  // R11
  no_flags_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (DEC_EN == 1'b0) |-> (!rd_sbe && !rd_dbe));

  if (OUT_REG) begin : g_oreg_chk
    // R9
    oreg_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      !oreg_ce |=> ($stable(rd_data) && $stable(rd_addr_out) && $stable(rd_sbe)));
    // R7
    oreg_addr_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (oreg_ce && $past(rd_en && !rd_rst)) |=> (rd_addr_out == $past(rd_addr, 2)));
    // R10
    always @(posedge rd_clk) begin
      if (prev_rst === 1'b1 && (PRIO == PRIO_RST || prev_ce === 1'b1))
        oreg_rst_chk: assert (rd_data == RST_VAL);
    end
  end else begin : g_direct_chk
    // R8
    read_hold_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      !rd_en |=> ($stable(rd_data) && $stable(rd_addr_out) && $stable(rd_sbe)));
    // R7
    addr_track_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_en |=> (rd_addr_out == $past(rd_addr)));
    // R12
    always @(posedge rd_clk) begin
      if (prev_rst === 1'b1)
        reset_state_chk: assert (rd_data == '0 && rd_addr_out == '0 && !rd_sbe && !rd_dbe);
    end
  end
endmodule

bind ecc_sdp_ram ecc_sdp_ram_chk #(
  .DW(DW), .AW(AW), .OUT_REG(OUT_REG), .DEC_EN(DEC_EN), .PRIO(PRIO), .RST_VAL(RST_VAL)
) u_chk (
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr), .oreg_ce(oreg_ce),
  .rd_data(rd_data), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe), .rd_addr_out(rd_addr_out)
);

// File: tb/ecc_sdp_ram_bench.sv
module ecc_sdp_ram_bench;
  import ecc_sdp_pkg::*;

  localparam logic [31:0] RV = 32'h5A5A_0F0F;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 0, rd_rst = 1, rd_en = 0, oreg_ce = 1;
  logic [10:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  wr_chk = '0;

  logic [31:0] a_data, b_data, c_data, d_data;
  logic        a_sbe, b_sbe, c_sbe, d_sbe, a_dbe, b_dbe, c_dbe, d_dbe;
  logic [10:0] a_addr, b_addr, c_addr, d_addr;
  logic [6:0]  a_enc, b_enc, c_enc, d_enc;

  ecc_sdp_ram #(.ENC_EN(1'b0)) u_ecc_sdp_ram (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(a_enc), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .oreg_ce(oreg_ce), .rd_data(a_data), .rd_sbe(a_sbe), .rd_dbe(a_dbe), .rd_addr_out(a_addr));

  ecc_sdp_ram #(.ENC_EN(1'b0), .DEC_EN(1'b0)) u_ecc_sdp_ram_raw (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(b_enc), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .oreg_ce(oreg_ce), .rd_data(b_data), .rd_sbe(b_sbe), .rd_dbe(b_dbe), .rd_addr_out(b_addr));

  ecc_sdp_ram #(.OUT_REG(1'b1), .PRIO(PRIO_RST), .RST_VAL(RV)) u_ecc_sdp_ram_reg (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(c_enc), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .oreg_ce(oreg_ce), .rd_data(c_data), .rd_sbe(c_sbe), .rd_dbe(c_dbe), .rd_addr_out(c_addr));

  ecc_sdp_ram #(.OUT_REG(1'b1), .PRIO(PRIO_CE), .RST_VAL(RV)) u_ecc_sdp_ram_cep (
    .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_chk(wr_chk),
    .enc_chk(d_enc), .rd_clk(clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .oreg_ce(oreg_ce), .rd_data(d_data), .rd_sbe(d_sbe), .rd_dbe(d_dbe), .rd_addr_out(d_addr));

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model of the stored check bits
  function automatic logic [6:0] model_chk(input logic [31:0] d);
    logic [38:0] cw;
    logic [5:0]  h;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    h = '0;
    for (int j = 0; j < 6; j++)
      for (int p = 1; p <= 38; p++)
        if (p[j]) h[j] = h[j] ^ cw[p];
    return {(^d) ^ (^h), h};
  endfunction

  typedef struct packed {
    logic [10:0] addr;
    logic [31:0] data;
    logic [31:0] raw;
    logic        sbe;
    logic        dbe;
  } exp_t;

  exp_t q[$];

  // driver tasks
  task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic [6:0] c);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_chk = c;
    #1 check(c_enc == model_chk(d), "R2", "enc_chk", {25'd0, c_enc}, {25'd0, model_chk(d)});
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [31:0] d, input logic [31:0] raw,
                    input logic s, input logic db);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    q.push_back('{addr: a, data: d, raw: raw, sbe: s, dbe: db});
    @(negedge clk);
    rd_en = 0;
  endtask

  // monitor: pops one expectation per completed read on the direct-output instances
  logic fired = 0, pend = 0, pend_dbe = 0;
  always @(posedge clk) fired <= rd_en && !rd_rst;

  always @(negedge clk) begin
    exp_t e;
    if (pend) begin
      check(a_dbe == pend_dbe, "R6", "rd_dbe one cycle late", {31'd0, a_dbe}, {31'd0, pend_dbe});
      pend = 0;
    end
    if (fired) begin
      if (q.size() == 0) begin
        check(1'b0, "R1", "unexpected read result", 32'd0, 32'd1);
      end else begin
        e = q.pop_front();
        check(a_data == e.data, e.sbe ? "R4" : (e.dbe ? "R6" : "R1"), "rd_data", a_data, e.data);
        check(a_sbe == e.sbe, "R4", "rd_sbe", {31'd0, a_sbe}, {31'd0, e.sbe});
        check(a_addr == e.addr, "R7", "rd_addr_out", {21'd0, a_addr}, {21'd0, e.addr});
        check(b_data == e.raw, "R11", "raw rd_data", b_data, e.raw);
        check(!b_sbe && !b_dbe, "R11", "raw flags", {30'd0, b_sbe, b_dbe}, 32'd0);
        pend = 1;
        pend_dbe = e.dbe;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [31:0] W0 = 32'h1234_5678, W5 = 32'hFFFF_FFFF, WT = 32'h8000_0001,
                          WH = 32'hA5C3_3C5A, D1 = 32'hCAFE_F00D, D2 = 32'h0BAD_BEEF,
                          D3 = 32'h1357_9BDF, D4 = 32'h2468_ACE0, D5 = 32'h7777_1111,
                          D6 = 32'h0F0F_F0F0;
  localparam logic [31:0] D5X = D5 ^ (32'd1 << 4) ^ (32'd1 << 17);

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state, R10 both priorities reset with enable high
    check(a_data == 0, "R12", "rd_data after reset", a_data, 0);
    check(a_addr == 0, "R12", "rd_addr_out after reset", {21'd0, a_addr}, 0);
    check(!a_sbe && !a_dbe, "R12", "flags after reset", {30'd0, a_sbe, a_dbe}, 0);
    check(c_data == RV, "R10", "reset-priority stage", c_data, RV);
    check(d_data == RV, "R10", "enable-priority stage with ce", d_data, RV);
    rd_rst = 0;

    // clean words and injected faults (R3: wr_chk stored when encoder is off)
    wr(11'd0,    W0, model_chk(W0));
    wr(11'd5,    W5, model_chk(W5));
    wr(11'd2047, WT, model_chk(WT));
    wr(11'd100,  WH, model_chk(WH));
    wr(11'd10, D1 ^ 32'h1,          model_chk(D1));
    wr(11'd11, D2 ^ 32'h8000_0000,  model_chk(D2));
    wr(11'd12, D3,                  model_chk(D3) ^ 7'h08);
    wr(11'd13, D4,                  model_chk(D4) ^ 7'h40);
    wr(11'd20, D5X,                 model_chk(D5));
    wr(11'd21, D6,                  model_chk(D6) ^ 7'h03);

    // R1 clean reads, R4 single faults, R6 double faults, R5 re-read
    rd(11'd0,    W0, W0, 0, 0);
    rd(11'd5,    W5, W5, 0, 0);
    rd(11'd2047, WT, WT, 0, 0);
    rd(11'd100,  WH, WH, 0, 0);
    rd(11'd10, D1, D1 ^ 32'h1, 1, 0);
    rd(11'd11, D2, D2 ^ 32'h8000_0000, 1, 0);
    rd(11'd12, D3, D3, 1, 0);
    rd(11'd13, D4, D4, 1, 0);
    rd(11'd20, D5X, D5X, 0, 1);
    rd(11'd21, D6, D6, 0, 1);
    rd(11'd10, D1, D1 ^ 32'h1, 1, 0);

    // R8 hold with read disabled, even across a write to the shown address
    rd_addr = 11'd5;
    wr(11'd10, 32'd0, model_chk(32'd0));
    repeat (2) @(negedge clk);
    check(a_data == D1, "R8", "held rd_data", a_data, D1);
    check(a_addr == 11'd10, "R8", "held rd_addr_out", {21'd0, a_addr}, 32'd10);
    check(a_sbe && !a_dbe, "R8", "held flags", {30'd0, a_sbe, a_dbe}, 32'd2);

    // R9 extra cycle of the output stage
    rd(11'd2047, WT, WT, 0, 0);
    check(c_data == (D1 ^ 32'h1), "R9", "stage not yet loaded", c_data, D1 ^ 32'h1);
    @(negedge clk);
    check(c_data == WT, "R9", "stage loaded", c_data, WT);
    check(c_addr == 11'd2047, "R7", "stage address", {21'd0, c_addr}, 32'd2047);

    // R3 encoder on: the corrupted write pattern is stored as a clean word
    rd(11'd20, D5X, D5X, 0, 1);
    @(negedge clk);
    check(c_data == D5X, "R3", "encoder-on data", c_data, D5X);
    check(!c_sbe, "R3", "encoder-on sbe", {31'd0, c_sbe}, 0);
    @(negedge clk);
    check(!c_dbe, "R3", "encoder-on dbe", {31'd0, c_dbe}, 0);

    // R9 enable low holds the stage
    oreg_ce = 0;
    rd(11'd0, W0, W0, 0, 0);
    @(negedge clk);
    check(c_data == D5X, "R9", "stage held", c_data, D5X);
    check(c_addr == 11'd20, "R9", "stage address held", {21'd0, c_addr}, 32'd20);

    // R10 reset priority
    rd_rst = 1;
    @(negedge clk);
    rd_rst = 0;
    check(c_data == RV, "R10", "reset beats enable", c_data, RV);
    check(d_data == D5X, "R10", "reset ignored without enable", d_data, D5X);
    rd_rst = 1; oreg_ce = 1;
    @(negedge clk);
    rd_rst = 0;
    check(d_data == RV, "R10", "reset with enable", d_data, RV);
    check(a_data == 0 && a_addr == 0, "R12", "mid-run reset", a_data, 0);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule